// File: doc/BRIEF.md
# Card Presence Debouncer

This block watches the card-presence pin of a smart-card slot and turns its noisy level into a clean present/absent state, with one-shot insert and removal events. The pin passes through a two-flop synchroniser, and a sample timer then takes periodic looks at it. A new level is accepted only after two looks in a row agree with it. Insertion is confirmed slowly and removal quickly: the insert sample period is three times the removal period, and the removal period comes from a 2-bit rate select.

Accepted events set sticky insert and removal flags. Software clears each flag by writing one to it, which reaches the block here as a single-cycle clear pulse. The OR of the two flags is the card-detect status, and it drives the interrupt line when the interrupt enable is set. When automatic deactivation is enabled, each accepted removal also raises a one-cycle request for the power-down sequencer to abort any activity and deactivate the card. The synchronised pin level is brought out unfiltered as a status bit.

Top module: `card_detect_filter`

## Requirements
- R1: While reset is active and on release, `card_present`, `insert_flag`, `remove_flag`, `cd_status`, `cd_irq` and `deact_req` are all 0.
- R2: `pin_level` follows `cd_pin` through two flip-flops: it shows the level `cd_pin` had two rising clock edges earlier, with no filtering.
- R3: A card counts as present when the synchronised pin equals `det_level`. With `det_level`=0 a high-to-low transition means insertion. With `det_level`=1 a low-to-high transition means insertion.
- R4: With `rate_sel` = 0, 1, 2, 3, the removal sample period is 128, 64, 32, 16 clocks. The insert sample period is three times that: 384, 192, 96, 48 clocks. The sample timer restarts whenever the engine is enabled and whenever the debounced state changes.
- R5: The debounced state changes only after two consecutive samples disagree with it. A pulse shorter than one sample period never changes the state.
- R6: An accepted insert sets `insert_flag` and an accepted removal sets `remove_flag`. Each flag stays set until its clear pulse (`clr_insert` or `clr_remove`) is high at a clock edge. If a set and a clear arrive on the same edge, the set wins.
- R7: `cd_status` is high whenever either flag is set. `cd_irq` is high only when `cd_status` and `irq_en` are both high.
- R8: While `eng_en` is 0, the debounced state is held at not-present, the sample timer is idle and no event is produced. Once the engine is enabled with a card already present, an insert event follows after two insert periods.
- R9: Each accepted removal produces a one-cycle pulse on `deact_req` when `auto_deact_en` is 1, and no pulse when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eng_en | input | 1 | Detection engine enable |
| cd_pin | input | 1 | Raw card-presence pin, asynchronous |
| det_level | input | 1 | Pin level that means card present |
| rate_sel | input | 2 | Sample rate select |
| auto_deact_en | input | 1 | Request deactivation on removal |
| irq_en | input | 1 | Card-detect interrupt enable |
| clr_insert | input | 1 | Write-one clear pulse for the insert flag |
| clr_remove | input | 1 | Write-one clear pulse for the removal flag |
| pin_level | output | 1 | Synchronised pin level |
| card_present | output | 1 | Debounced presence state |
| insert_flag | output | 1 | Sticky insert event flag |
| remove_flag | output | 1 | Sticky removal event flag |
| cd_status | output | 1 | Combined card-detect status |
| cd_irq | output | 1 | Card-detect interrupt |
| deact_req | output | 1 | One-cycle deactivation request |

## Verification
On every cycle, the assertions check the following: interrupt gating by the enable and the status, the stickiness of both flags until cleared, that the presence state stays absent and changes only while the engine runs, and that a deactivation request comes only with automatic deactivation enabled and together with a set removal flag. Several behaviours can only be shown by the bench's timed scenarios: the actual sample periods at different rate selects, the three-to-one insert/removal ratio, the rejection of a short glitch, and both detect polarities. It checks each of these inside a window of cycles worked out from the periods.

// File: rtl/card_detect_filter.sv
module card_detect_filter #(
  parameter int REM_BASE = 128,
  parameter int INS_MULT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eng_en,
  input  logic       cd_pin,
  input  logic       det_level,
  input  logic [1:0] rate_sel,
  input  logic       auto_deact_en,
  input  logic       irq_en,
  input  logic       clr_insert,
  input  logic       clr_remove,
  output logic       pin_level,
  output logic       card_present,
  output logic       insert_flag,
  output logic       remove_flag,
  output logic       cd_status,
  output logic       cd_irq,
  output logic       deact_req
);
  localparam int CW = $clog2(REM_BASE * INS_MULT + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] rem_per;
  logic [CW-1:0] period;
  logic          pend_q;
  logic          tick;
  logic          seen_present;
  logic          differs;
  logic          flip;
  logic          ins_evt;
  logic          rem_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], cd_pin};

  assign pin_level    = sync_q[1];
  assign seen_present = (pin_level == det_level);

  assign rem_per = CW'(REM_BASE >> rate_sel);
  assign period  = card_present ? rem_per : CW'(INS_MULT) * rem_per;
  assign tick    = eng_en && (cnt_q >= period - CW'(1));
  assign differs = seen_present != card_present;
  assign flip    = tick && differs && pend_q;
  assign ins_evt = flip && !card_present;
  assign rem_evt = flip &&  card_present;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   cnt_q <= '0;
    else if (!eng_en || tick)     cnt_q <= '0;
    else                          cnt_q <= cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q       <= 1'b0;
      card_present <= 1'b0;
    end else if (!eng_en) begin
      pend_q       <= 1'b0;
      card_present <= 1'b0;
    end else if (tick) begin
      pend_q <= differs && !pend_q;
      if (flip) card_present <= seen_present;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      insert_flag <= 1'b0;
      remove_flag <= 1'b0;
      deact_req   <= 1'b0;
    end else begin
      if (ins_evt)         insert_flag <= 1'b1;
      else if (clr_insert) insert_flag <= 1'b0;
      if (rem_evt)         remove_flag <= 1'b1;
      else if (clr_remove) remove_flag <= 1'b0;
      deact_req <= rem_evt && auto_deact_en;
    end

  assign cd_status = insert_flag | remove_flag;
  assign cd_irq    = cd_status & irq_en;
endmodule

module card_detect_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic eng_en,
  input logic auto_deact_en,
  input logic irq_en,
  input logic clr_insert,
  input logic clr_remove,
  input logic card_present,
  input logic insert_flag,
  input logic remove_flag,
  input logic cd_irq,
  input logic deact_req
);
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cd_irq |-> (irq_en && (insert_flag || remove_flag)));

  p_ins_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (insert_flag && !clr_insert) |=> insert_flag);

  p_rem_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (remove_flag && !clr_remove) |=> remove_flag);

  p_off_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_en |=> !card_present);

  p_change_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_present) |-> $past(eng_en));

  p_deact_auto_r9: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |-> (remove_flag && $past(auto_deact_en)));

  p_deact_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |=> !deact_req);
endmodule

bind card_detect_filter card_detect_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .auto_deact_en(auto_deact_en),
  .irq_en(irq_en), .clr_insert(clr_insert), .clr_remove(clr_remove),
  .card_present(card_present), .insert_flag(insert_flag),
  .remove_flag(remove_flag), .cd_irq(cd_irq), .deact_req(deact_req)
);

// File: tb/card_detect_filter_tb.sv
module card_detect_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eng_en = 1'b0, cd_pin = 1'b1, det_level = 1'b0;
  logic [1:0] rate_sel = 2'd3;
  logic auto_deact_en = 1'b0, irq_en = 1'b0, clr_insert = 1'b0, clr_remove = 1'b0;
  logic pin_level, card_present, insert_flag, remove_flag, cd_status, cd_irq, deact_req;
  int total = 0, bad = 0, deact_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  card_detect_filter u_dut (
    .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .cd_pin(cd_pin),
    .det_level(det_level), .rate_sel(rate_sel), .auto_deact_en(auto_deact_en),
    .irq_en(irq_en), .clr_insert(clr_insert), .clr_remove(clr_remove),
    .pin_level(pin_level), .card_present(card_present),
    .insert_flag(insert_flag), .remove_flag(remove_flag),
    .cd_status(cd_status), .cd_irq(cd_irq), .deact_req(deact_req)
  );

  always @(posedge clk) if (deact_req) deact_cnt <= deact_cnt + 1;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    clr_insert = 1'b1; clr_remove = 1'b1;
    wait_n(1);
    clr_insert = 1'b0; clr_remove = 1'b0;
  endtask

  task automatic t_reset();
    wait_n(3);
    chk("R1 present in reset", card_present, 0);
    chk("R1 status in reset", cd_status, 0);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1 insert flag", insert_flag, 0);
    chk("R1 remove flag", remove_flag, 0);
    chk("R1 irq", cd_irq, 0);
    chk("R1 deact", deact_req, 0);
  endtask

  task automatic t_pin_level();
    cd_pin = 1'b0;
    wait_n(1);
    chk("R2 not yet through", pin_level, 1);
    wait_n(1);
    chk("R2 low after two edges", pin_level, 0);
    cd_pin = 1'b1;
    wait_n(2);
    chk("R2 high after two edges", pin_level, 1);
  endtask

  task automatic t_enable_insert();
    det_level = 1'b0; rate_sel = 2'd3; cd_pin = 1'b0;
    wait_n(10);
    chk("R8 no detect while off", insert_flag, 0);
    eng_en = 1'b1;
    wait_n(90);
    chk("R4 insert not before two 48-clock samples", card_present, 0);
    wait_n(10);
    chk("R3 low pin present with level 0", card_present, 1);
    chk("R6 insert flag set", insert_flag, 1);
    chk("R7 status", cd_status, 1);
    chk("R7 irq masked", cd_irq, 0);
    irq_en = 1'b1;
    #1;
    chk("R7 irq enabled", cd_irq, 1);
    wait_n(20);
    chk("R6 insert flag sticky", insert_flag, 1);
    clr_insert = 1'b1;
    wait_n(1);
    clr_insert = 1'b0;
    chk("R6 insert flag cleared", insert_flag, 0);
    chk("R7 status cleared", cd_status, 0);
    chk("R7 irq cleared", cd_irq, 0);
  endtask

  task automatic t_remove_auto();
    int d0 = deact_cnt;
    auto_deact_en = 1'b1;
    cd_pin = 1'b1;
    wait_n(15);
    chk("R4 removal not before 16-clock samples", card_present, 1);
    wait_n(25);
    chk("R4 removal within two 16-clock samples", card_present, 0);
    chk("R6 remove flag set", remove_flag, 1);
    chk("R9 one deact pulse", deact_cnt - d0, 1);
    clear_flags();
    chk("R6 remove flag cleared", remove_flag, 0);
  endtask

  task automatic t_glitch();
    int d0;
    cd_pin = 1'b0;
    wait_n(110);
    chk("R5 reinsert accepted", card_present, 1);
    clear_flags();
    d0 = deact_cnt;
    cd_pin = 1'b1;
    wait_n(3);
    cd_pin = 1'b0;
    wait_n(100);
    chk("R5 glitch ignored present", card_present, 1);
    chk("R5 glitch no removal flag", remove_flag, 0);
    chk("R5 glitch no deact", deact_cnt - d0, 0);
  endtask

  task automatic t_remove_manual();
    int d0 = deact_cnt;
    auto_deact_en = 1'b0;
    cd_pin = 1'b1;
    wait_n(40);
    chk("R9 removal seen", remove_flag, 1);
    chk("R9 no deact when auto off", deact_cnt - d0, 0);
    clear_flags();
  endtask

  task automatic t_slow_rates();
    rate_sel = 2'd0;
    cd_pin = 1'b0;
    wait_n(383);
    chk("R4 sel0 insert not before 384", card_present, 0);
    wait_n(389);
    chk("R4 sel0 insert within two 384 samples", card_present, 1);
    clear_flags();
    rate_sel = 2'd1;
    cd_pin = 1'b1;
    wait_n(63);
    chk("R4 sel1 removal not before 64", card_present, 1);
    wait_n(69);
    chk("R4 sel1 removal within two 64 samples", card_present, 0);
    clear_flags();
  endtask

  task automatic t_disable();
    cd_pin = 1'b0;
    wait_n(400);
    chk("R8 present before disable", card_present, 1);
    clear_flags();
    eng_en = 1'b0;
    wait_n(2);
    chk("R8 disable forces absent", card_present, 0);
    cd_pin = 1'b1;
    wait_n(500);
    cd_pin = 1'b0;
    wait_n(500);
    cd_pin = 1'b1;
    wait_n(10);
    chk("R8 no insert while off", insert_flag, 0);
    chk("R8 no removal while off", remove_flag, 0);
    eng_en = 1'b1;
    wait_n(500);
    chk("R8 enable with card absent no event", cd_status, 0);
    chk("R8 still absent", card_present, 0);
  endtask

  task automatic t_polarity();
    eng_en = 1'b0; det_level = 1'b1; rate_sel = 2'd3; cd_pin = 1'b1;
    wait_n(5);
    eng_en = 1'b1;
    wait_n(100);
    chk("R3 high pin present with level 1", card_present, 1);
    chk("R3 insert flag level 1", insert_flag, 1);
    clear_flags();
    cd_pin = 1'b0;
    wait_n(40);
    chk("R3 low pin removal with level 1", remove_flag, 1);
    chk("R3 absent after removal", card_present, 0);
  endtask

  initial begin
    t_reset();
    t_pin_level();
    t_enable_insert();
    t_remove_auto();
    t_glitch();
    t_remove_manual();
    t_slow_rates();
    t_disable();
    t_polarity();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule